// File: doc/BRIEF.md
# Host IN Request Scheduler

This block decides, for one host IN pipe, when an IN token should be sent. Each time the bus offers the pipe a transaction slot (`slot_i`), the scheduler either issues a one-cycle IN request or stays idle.

It has two modes, selected by `cont_mode_i`:

- **Counted mode** (0): the scheduler issues one more request than the programmed count and then freezes the pipe on its own.
- **Continuous mode** (1): it keeps issuing requests until software freezes the pipe.

No request is issued while any of the following holds:

- the pipe is frozen;
- the pipe is not configured;
- a received bank is still held by software.

When the FIFO reports that the current bank has filled, two flags rise in the same cycle: the received-data flag and the FIFO-control flag. Software clears the received-data flag with a write-one-to-clear strobe. It clears the FIFO-control flag by releasing the bank. An interrupt output combines the received-data flag with its enable bit.

Top module: `host_in_sched`

## Requirements
- R1: After reset, `frozen_o` is 1. `in_req_o`, `auto_frz_o`, `rxd_flag_o`, `fifo_ctl_o` and `irq_o` are 0.
- R2: In counted mode (`cont_mode_i`=0), after the freeze is cleared the block issues exactly `req_cnt_i`+1 requests and then no more. `auto_frz_o` pulses in the same cycle as the last request, and `frozen_o` is 1 from that cycle on.
- R3: In continuous mode (`cont_mode_i`=1), every slot yields a request while the pipe is unfrozen, and `auto_frz_o` never pulses.
- R4: While `frozen_o` is 1, slots yield no request. `frz_set_i` sets `frozen_o` one cycle later and `frz_clr_i` clears it one cycle later. If both strobes arrive in the same cycle, the set wins.
- R5: A `frz_clr_i` strobe reloads the remaining-request budget from `req_cnt_i`, so a restart after a manual freeze again yields `req_cnt_i`+1 requests.
- R6: While `cfg_done_i` is 0, slots yield no request.
- R7: A slot strobe in cycle t produces at most one request: a single-cycle `in_req_o` pulse in cycle t+1.
- R8: A `bank_full_i` strobe sets `rxd_flag_o` and `fifo_ctl_o` together one cycle later. No request is issued in a cycle where `bank_full_i` or `fifo_ctl_o` is 1.
- R9: `rxd_clr_i` clears only `rxd_flag_o`, and `bank_rel_i` clears only `fifo_ctl_o`. A `bank_full_i` strobe in the same cycle as either clear wins over it.
- R10: `irq_o` is 1 exactly when `rxd_flag_o` and `rxd_ie_i` are both 1. It follows `rxd_ie_i` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_done_i | input | 1 | Pipe is configured |
| cont_mode_i | input | 1 | 0: counted mode, 1: continuous mode |
| req_cnt_i | input | CNT_W | Programmed request count (requests issued = value + 1) |
| frz_set_i | input | 1 | Software freeze strobe |
| frz_clr_i | input | 1 | Software unfreeze strobe; also reloads the budget |
| slot_i | input | 1 | Transaction opportunity strobe |
| bank_full_i | input | 1 | Current bank has filled (strobe) |
| bank_rel_i | input | 1 | Software releases the bank (clears `fifo_ctl_o`) |
| rxd_clr_i | input | 1 | Write-one-to-clear for `rxd_flag_o` |
| rxd_ie_i | input | 1 | Received-data interrupt enable |
| in_req_o | output | 1 | IN request pulse |
| auto_frz_o | output | 1 | Pulse marking the automatic freeze |
| frozen_o | output | 1 | Pipe freeze state |
| rxd_flag_o | output | 1 | Received-data flag |
| fifo_ctl_o | output | 1 | FIFO-control flag (bank held by software) |
| irq_o | output | 1 | Received-data interrupt |

## Verification
A corrupted remaining-request counter shows up only in counted mode, as a wrong number of `in_req_o` pulses between an unfreeze and the automatic freeze. It therefore becomes visible at the end of a run, up to `req_cnt_i`+1 slots later. The directed tests use small counts, including zero, and a manual freeze part way through a run, so that both the reload and the terminal count are exposed.

A stuck freeze bit or a stuck bank-pending flag appears at the very next slot, as a missing or unexpected request. A flag that fails to clear is seen one cycle after its clear strobe.

// File: rtl/his_pkg.sv
package his_pkg;
  typedef enum logic {
    MODE_COUNTED = 1'b0,
    MODE_ENDLESS = 1'b1
  } his_mode_e;
endpackage

// File: rtl/his_req_counter.sv
module his_req_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam int REM_W = CNT_W + 1;

  logic [REM_W-1:0] rem_q;

  // budget holds requests still to be issued (count + 1 after a load)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rem_q <= '0;
    else if (load_i)                   rem_q <= REM_W'(cnt_i) + REM_W'(1);
    else if (dec_i && rem_q != '0)     rem_q <= rem_q - REM_W'(1);
  end

  assign last_o = (rem_q == REM_W'(1));
endmodule

// File: rtl/his_freeze_ctl.sv
module his_freeze_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic frozen_o
);
  // pipe comes out of reset frozen; a set wins over a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frozen_o <= 1'b1;
    else if (set_i)  frozen_o <= 1'b1;
    else if (clr_i)  frozen_o <= 1'b0;
  end
endmodule

// File: rtl/his_rx_flags.sv
module his_rx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_i,
  input  logic rxd_clr_i,
  input  logic rel_i,
  output logic rxd_o,
  output logic fctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_o  <= 1'b0;
      fctl_o <= 1'b0;
    end else begin
      if (full_i)         rxd_o <= 1'b1;
      else if (rxd_clr_i) rxd_o <= 1'b0;
      if (full_i)         fctl_o <= 1'b1;
      else if (rel_i)     fctl_o <= 1'b0;
    end
  end
endmodule

// File: rtl/host_in_sched.sv
module host_in_sched
  import his_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_done_i,
  input  logic             cont_mode_i,
  input  logic [CNT_W-1:0] req_cnt_i,
  input  logic             frz_set_i,
  input  logic             frz_clr_i,
  input  logic             slot_i,
  input  logic             bank_full_i,
  input  logic             bank_rel_i,
  input  logic             rxd_clr_i,
  input  logic             rxd_ie_i,
  output logic             in_req_o,
  output logic             auto_frz_o,
  output logic             frozen_o,
  output logic             rxd_flag_o,
  output logic             fifo_ctl_o,
  output logic             irq_o
);
  his_mode_e mode;
  logic      issue, last, auto_hit, counted;

  assign mode    = his_mode_e'(cont_mode_i);
  assign counted = (mode == MODE_COUNTED);

  // no issue while a software freeze strobe is in flight or a bank is pending
  assign issue = slot_i && cfg_done_i && !frozen_o && !frz_set_i && !frz_clr_i
               && !fifo_ctl_o && !bank_full_i;
  assign auto_hit = issue && counted && last;

  his_req_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frz_clr_i),
    .cnt_i  (req_cnt_i),
    .dec_i  (issue && counted),
    .last_o (last)
  );

  his_freeze_ctl u_frz (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (frz_set_i || auto_hit),
    .clr_i    (frz_clr_i),
    .frozen_o (frozen_o)
  );

  his_rx_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .full_i    (bank_full_i),
    .rxd_clr_i (rxd_clr_i),
    .rel_i     (bank_rel_i),
    .rxd_o     (rxd_flag_o),
    .fctl_o    (fifo_ctl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_req_o   <= 1'b0;
      auto_frz_o <= 1'b0;
    end else begin
      in_req_o   <= issue;
      auto_frz_o <= auto_hit;
    end
  end

  assign irq_o = rxd_flag_o && rxd_ie_i;
endmodule

// File: rtl/host_in_sched_chk.sv
module host_in_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_done_i,
  input logic cont_mode_i,
  input logic slot_i,
  input logic bank_full_i,
  input logic in_req_o,
  input logic auto_frz_o,
  input logic frozen_o,
  input logic rxd_flag_o,
  input logic fifo_ctl_o
);
  assert_no_req_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_req_o |-> $past(!frozen_o));

  assert_req_needs_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_req_o |-> $past(slot_i));

  assert_req_needs_cfg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_req_o |-> $past(cfg_done_i));

  assert_no_req_bank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_req_o |-> $past(!fifo_ctl_o && !bank_full_i));

  assert_flags_paired_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_full_i |=> (rxd_flag_o && fifo_ctl_o));

  assert_auto_frz_last_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_frz_o |-> (in_req_o && frozen_o));

  assert_no_auto_endless_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_frz_o |-> $past(!cont_mode_i));
endmodule

bind host_in_sched host_in_sched_chk u_chk (.*);

// File: tb/host_in_sched_tb_top.sv
module host_in_sched_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_done = 1'b0, cont_mode = 1'b0, frz_set = 1'b0, frz_clr = 1'b0;
  logic slot = 1'b0, bank_full = 1'b0, bank_rel = 1'b0, rxd_clr = 1'b0, rxd_ie = 1'b0;
  logic [CNT_W-1:0] req_cnt = '0;
  logic in_req, auto_frz, frozen, rxd_flag, fifo_ctl, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  host_in_sched #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_done_i(cfg_done), .cont_mode_i(cont_mode),
    .req_cnt_i(req_cnt), .frz_set_i(frz_set), .frz_clr_i(frz_clr), .slot_i(slot),
    .bank_full_i(bank_full), .bank_rel_i(bank_rel), .rxd_clr_i(rxd_clr), .rxd_ie_i(rxd_ie),
    .in_req_o(in_req), .auto_frz_o(auto_frz), .frozen_o(frozen), .rxd_flag_o(rxd_flag),
    .fifo_ctl_o(fifo_ctl), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one slot strobe; samples the request and auto-freeze outputs in the following cycle
  task automatic do_slot(output logic r, output logic af);
    @(negedge clk) slot = 1'b1;
    @(posedge clk) #1;
    r  = in_req;
    af = auto_frz;
    @(negedge clk) slot = 1'b0;
  endtask

  task automatic unfreeze();
    @(negedge clk) frz_clr = 1'b1;
    @(negedge clk) frz_clr = 1'b0;
  endtask

  task automatic freeze();
    @(negedge clk) frz_set = 1'b1;
    @(negedge clk) frz_set = 1'b0;
  endtask

  task automatic run_slots(input int n, output int reqs, output int afs, output int af_at);
    logic r, af;
    reqs = 0; afs = 0; af_at = -1;
    for (int i = 0; i < n; i++) begin
      do_slot(r, af);
      if (r) reqs++;
      if (af) begin afs++; af_at = reqs; end
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 frozen", int'(frozen), 1);
    chk("R1 in_req", int'(in_req), 0);
    chk("R1 auto_frz", int'(auto_frz), 0);
    chk("R1 flags", int'({rxd_flag, fifo_ctl, irq}), 0);
  endtask

  task automatic t_counted(input int cnt);
    int reqs, afs, af_at;
    cont_mode = 1'b0;
    req_cnt = CNT_W'(cnt);
    unfreeze();
    run_slots(cnt + 4, reqs, afs, af_at);
    chk("R2 request count", reqs, cnt + 1);
    chk("R2 single auto freeze", afs, 1);
    chk("R2 auto freeze on last request", af_at, cnt + 1);
    chk("R2 frozen after run", int'(frozen), 1);
  endtask

  task automatic t_reload();
    int reqs, afs, af_at;
    cont_mode = 1'b0;
    req_cnt = CNT_W'(2);
    unfreeze();
    run_slots(2, reqs, afs, af_at);
    chk("R5 partial run", reqs, 2);
    freeze();
    chk("R4 manual freeze", int'(frozen), 1);
    run_slots(2, reqs, afs, af_at);
    chk("R4 no request while frozen", reqs, 0);
    unfreeze();
    run_slots(6, reqs, afs, af_at);
    chk("R5 reload gives full budget", reqs, 3);
  endtask

  task automatic t_endless();
    int reqs, afs, af_at;
    cont_mode = 1'b1;
    req_cnt = CNT_W'(1);
    unfreeze();
    run_slots(10, reqs, afs, af_at);
    chk("R3 request every slot", reqs, 10);
    chk("R3 no auto freeze", afs, 0);
    chk("R3 still unfrozen", int'(frozen), 0);
  endtask

  task automatic t_pulse_shape();
    logic r, af;
    cont_mode = 1'b1;
    @(negedge clk) slot = 1'b1;
    @(negedge clk) slot = 1'b0;
    #1 chk("R7 request one cycle after slot", int'(in_req), 1);
    @(posedge clk) #1 chk("R7 request is single cycle", int'(in_req), 0);
    do_slot(r, af);
    chk("R7 next slot gives request", int'(r), 1);
  endtask

  task automatic t_set_wins();
    @(negedge clk) begin frz_set = 1'b1; frz_clr = 1'b1; end
    @(negedge clk) begin frz_set = 1'b0; frz_clr = 1'b0; end
    chk("R4 set wins over clear", int'(frozen), 1);
    unfreeze();
    chk("R4 clear unfreezes", int'(frozen), 0);
  endtask

  task automatic t_unconf();
    int reqs, afs, af_at;
    cont_mode = 1'b1;
    cfg_done = 1'b0;
    run_slots(3, reqs, afs, af_at);
    chk("R6 no request when unconfigured", reqs, 0);
    cfg_done = 1'b1;
    run_slots(1, reqs, afs, af_at);
    chk("R6 request once configured", reqs, 1);
  endtask

  task automatic t_bank();
    logic r, af;
    cont_mode = 1'b1;
    @(negedge clk) begin bank_full = 1'b1; slot = 1'b1; end
    @(negedge clk) begin bank_full = 1'b0; slot = 1'b0; end
    chk("R8 no request with bank_full slot", int'(in_req), 0);
    chk("R8 flags paired", int'({rxd_flag, fifo_ctl}), 3);
    do_slot(r, af);
    chk("R8 no request while bank held", int'(r), 0);
    @(negedge clk) bank_rel = 1'b1;
    @(negedge clk) bank_rel = 1'b0;
    chk("R9 release clears fifo_ctl", int'(fifo_ctl), 0);
    chk("R9 release keeps rxd flag", int'(rxd_flag), 1);
    rxd_ie = 1'b0;
    #1 chk("R10 irq masked", int'(irq), 0);
    rxd_ie = 1'b1;
    #1 chk("R10 irq enabled", int'(irq), 1);
    do_slot(r, af);
    chk("R8 request after release", int'(r), 1);
    @(negedge clk) rxd_clr = 1'b1;
    @(negedge clk) rxd_clr = 1'b0;
    chk("R9 w1c clears rxd flag", int'(rxd_flag), 0);
    chk("R10 irq drops with flag", int'(irq), 0);
    @(negedge clk) begin bank_full = 1'b1; bank_rel = 1'b1; rxd_clr = 1'b1; end
    @(negedge clk) begin bank_full = 1'b0; bank_rel = 1'b0; rxd_clr = 1'b0; end
    chk("R9 set wins over clears", int'({rxd_flag, fifo_ctl}), 3);
    @(negedge clk) begin bank_rel = 1'b1; rxd_clr = 1'b1; end
    @(negedge clk) begin bank_rel = 1'b0; rxd_clr = 1'b0; end
    rxd_ie = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        cfg_done = 1'b1;
        t_counted(3);
        t_counted(0);
        t_counted(7);
        t_reload();
        t_endless();
        t_pulse_shape();
        t_set_wins();
        t_unconf();
        t_bank();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule